// File: doc/BRIEF.md
# Multiplier-free L1 magnitude and base-2 logarithm

This block takes one complex value, given as two signed two's-complement parts, and returns a fixed-point base-2 logarithm of its L1 magnitude. The magnitude is |real| + |imaginary|. Each part's sign is tested, and that part is negated inside the same sum. The logarithm has an integer field and a fraction field. The integer field is the position of the magnitude's leading one, found by a thermometer-style encoder. The fraction field comes from a 32-entry table that is indexed by the bits that follow the leading one.

To find those bits, the block loads the magnitude into a register and shifts it left by one position per clock until the leading one reaches the top bit. The work needs no multiplier and no divider. The conversion time depends on the input size: larger magnitudes finish sooner. A caller pulses `start` with the operands present, waits while `busy` is high and takes the result on the one-cycle `done` pulse. The result stays on the outputs until the next conversion finishes.

Top module: `l1_log2_conv`

## Requirements
- R1: The magnitude is |re| + |im|, with both inputs read as signed W-bit two's complement. This includes -2^(W-1), so the magnitude ranges from 0 to 2^W (W+1 bits).
- R2: For a non-zero magnitude, the integer field is the bit index of its most significant set bit, where bit 0 is the LSB.
- R3: The fraction field is floor(32·log2(1 + j/32)). Here j is the 5-bit value formed by the five magnitude bits directly below the leading one, most significant first, with missing bits below bit 0 read as zero.
- R4: log_out is laid out as {integer field, 5-bit fraction}: the fraction occupies bits 4..0 and the integer field occupies the bits above it.
- R5: A start is accepted on a rising edge where busy is low. For a non-zero magnitude with integer field e, done is high for exactly one cycle, after the (W - e + 1)-th rising edge that follows the accepting edge.
- R6: busy rises on the accepting edge of a non-zero conversion. It falls on the same edge that raises done, and it is never high together with done.
- R7: A zero magnitude does not set busy. done is high for one cycle after the accepting edge, log_out is 0 and zero is 1. Any later non-zero result clears zero.
- R8: start, re and im have no effect while busy is high. The pending conversion completes with its own operands and its own timing.
- R9: While reset is asserted (rst_n low) and after it is released, log_out, zero, done and busy are all 0 until the first start is accepted.
- R10: log_out and zero hold their last result until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Conversion request, taken when not busy |
| re | input | W | Real part, signed |
| im | input | W | Imaginary part, signed |
| log_out | output | clog2(W+1)+5 | {integer field, 5-bit fraction} of log2 of the magnitude |
| zero | output | 1 | Last result came from a zero magnitude |
| done | output | 1 | One-cycle result-ready pulse |
| busy | output | 1 | Normalizing shift in progress |

## Verification
The assertions assume that reset is applied before the first start. They make no assumption about start timing: a start may arrive during busy, during the done cycle or on consecutive cycles, and the design is required to absorb it. The stimulus therefore drives start both while the block is busy and in the cycle right after done. It also includes all-zero operands and both extremes of the signed range, so that the shift count runs from zero up to W.

// File: rtl/l1_log2_pkg.sv
package l1_log2_pkg;
  localparam int FRW = 5;
  localparam int TBL_N = 32;

  // floor(32*log2(1 + j/32)) by repeated squaring in Q30 fixed point
  function automatic logic [FRW-1:0] log_frac(input int j);
    longint unsigned y;
    logic [FRW-1:0] r;
    y = longint'(32 + j) << 25;
    r = '0;
    for (int b = FRW - 1; b >= 0; b--) begin
      y = (y * y) >> 30;
      if (y >= (64'd1 << 31)) begin
        r[b] = 1'b1;
        y = y >> 1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/l1_mag.sv
module l1_mag #(
  parameter int W = 16,
  localparam int MW = W + 1
) (
  input  logic signed [W-1:0] re,
  input  logic signed [W-1:0] im,
  output logic        [MW-1:0] mag
);
  // sign test and conditional negate, widened by one bit so -2^(W-1) fits
  function automatic logic [MW-1:0] abs_ext(input logic signed [W-1:0] v);
    logic signed [MW-1:0] x;
    x = MW'(v);
    return v[W-1] ? MW'(-x) : MW'(x);
  endfunction

  assign mag = abs_ext(re) + abs_ext(im);
endmodule

// File: rtl/lead_one_enc.sv
module lead_one_enc #(
  parameter int MW = 17,
  localparam int EXPW = $clog2(MW)
) (
  input  logic [MW-1:0]   val,
  output logic [EXPW-1:0] pos,
  output logic            is_zero
);
  logic [MW-1:0] therm;

  // therm[i] is set when any bit at or above i is set
  for (genvar i = 0; i < MW; i++) begin : g_therm
    assign therm[i] = |val[MW-1:i];
  end

  assign is_zero = ~therm[0];
  assign pos     = EXPW'($countones(therm) - 1);
endmodule

// File: rtl/log_frac_rom.sv
module log_frac_rom
  import l1_log2_pkg::*;
(
  input  logic [FRW-1:0] idx,
  output logic [FRW-1:0] frac
);
  logic [FRW-1:0] tbl [TBL_N];

  for (genvar i = 0; i < TBL_N; i++) begin : g_tbl
    assign tbl[i] = log_frac(i);
  end

  assign frac = tbl[idx];
endmodule

// File: rtl/l1_log2_conv.sv
module l1_log2_conv
  import l1_log2_pkg::*;
#(
  parameter int W = 16,
  localparam int MW = W + 1,
  localparam int EXPW = $clog2(MW),
  localparam int OW = EXPW + FRW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] re,
  input  logic signed [W-1:0] im,
  output logic [OW-1:0]       log_out,
  output logic                zero,
  output logic                done,
  output logic                busy
);
  logic [MW-1:0]   mag;
  logic [EXPW-1:0] lead_e;
  logic            mag_is_zero;
  logic [MW-1:0]   sreg;
  logic [EXPW-1:0] exp_q;
  logic [EXPW-1:0] cnt;
  logic [FRW-1:0]  frac;
  logic [OW-1:0]   log_q;
  logic            busy_q, done_q, zero_q;

  // named events for the assertions
  logic accept, finish;
  assign accept = start & ~busy_q;
  assign finish = busy_q & (cnt == '0);

  l1_mag #(.W(W)) u_mag (.re(re), .im(im), .mag(mag));

  lead_one_enc #(.MW(MW)) u_lead (.val(mag), .pos(lead_e), .is_zero(mag_is_zero));

  log_frac_rom u_rom (.idx(sreg[MW-2 -: FRW]), .frac(frac));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      zero_q <= 1'b0;
      log_q  <= '0;
      sreg   <= '0;
      exp_q  <= '0;
      cnt    <= '0;
    end else begin
      done_q <= 1'b0;
      if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        zero_q <= 1'b0;
        log_q  <= {exp_q, frac};
      end else if (busy_q) begin
        sreg <= sreg << 1;
        cnt  <= cnt - 1'b1;
      end else if (accept) begin
        if (mag_is_zero) begin
          done_q <= 1'b1;
          zero_q <= 1'b1;
          log_q  <= '0;
        end else begin
          busy_q <= 1'b1;
          sreg   <= mag;
          exp_q  <= lead_e;
          cnt    <= EXPW'(W) - lead_e;
        end
      end
    end
  end

  assign log_out = log_q;
  assign zero    = zero_q;
  assign done    = done_q;
  assign busy    = busy_q;

  // the shift count lands the leading one exactly on the top bit (R2, R3)
  p_norm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> sreg[MW-1]);

  // magnitude never exceeds 2^W (R1)
  p_mag_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(mag) <= (32'd1 << W));

  // done and busy are exclusive (R6)
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // a busy period always ends with a done pulse (R5)
  p_busy_ends_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // operands captured at accept are not disturbed mid-conversion (R8)
  p_hold_exp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !finish) |=> $stable(exp_q));

  // zero-magnitude result reads as 0 (R7)
  p_zero_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && zero_q) |-> (log_q == '0));
endmodule

// File: tb/sim_l1_log2_conv.sv
module sim_l1_log2_conv;
  localparam int W = 16;
  localparam int EXPW = $clog2(W + 1);
  localparam int OW = EXPW + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [W-1:0] re = '0, im = '0;
  logic [OW-1:0] log_out;
  logic zero, done, busy;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string phase = "R9 reset";

  // reference model state
  int m_busy = 0, m_done = 0, m_zero = 0, m_log = 0, m_cnt = 0, m_pend = 0;

  always #2 clk = ~clk; // 250 MHz

  l1_log2_conv #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .re(re), .im(im),
    .log_out(log_out), .zero(zero), .done(done), .busy(busy)
  );

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  // expected {e, frac} for a non-zero magnitude, built from R2..R4
  function automatic int ref_log(input int m, output int e);
    int j, f;
    e = 0;
    while ((m >> (e + 1)) != 0) e++;
    j = ((m << 5) >> e) & 31;
    f = $rtoi($floor(32.0 * $ln(1.0 + j / 32.0) / $ln(2.0)));
    return e * 32 + f;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_zero = 0; m_log = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_zero = 0; m_log = m_pend;
        end else m_cnt--;
      end else if (start) begin
        int m, e;
        m = iabs(int'(re)) + iabs(int'(im));
        if (m == 0) begin
          m_done = 1; m_zero = 1; m_log = 0;
        end else begin
          m_pend = ref_log(m, e);
          m_cnt = W - e;
          m_busy = 1;
        end
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    n_chk++;
    if (busy !== (m_busy != 0)) begin
      n_bad++; $display("FAIL %s R6 busy: got %0b exp %0d", phase, busy, m_busy);
    end else if (done !== (m_done != 0)) begin
      n_bad++; $display("FAIL %s R5 done: got %0b exp %0d", phase, done, m_done);
    end else if (zero !== (m_zero != 0)) begin
      n_bad++; $display("FAIL %s R7 zero: got %0b exp %0d", phase, zero, m_zero);
    end else if (int'(log_out) != m_log || $isunknown(log_out)) begin
      n_bad++;
      $display("FAIL %s R1 R2 R3 R4 R10 log_out: got %0d exp %0d", phase, log_out, m_log);
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles exp completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic pulse(input int a, input int b);
    @(negedge clk);
    start = 1'b1; re = W'(a); im = W'(b);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input int a, input int b);
    pulse(a, b);
    while (m_busy != 0 || m_done != 0) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk); // R9 outputs idle after release
    phase = "R1 R2 R3 directed";
    run(1, 0); run(0, -1); run(-1, -1); run(3, 4); run(31, 1);
    run(-32768, -32768);          // magnitude 2^16, no shift
    run(32767, 32767); run(-32768, 0); run(100, -200);
    phase = "R7 zero";
    run(0, 0); run(5, 0);          // zero flag cleared by non-zero result
    run(0, 0); run(0, 0);
    phase = "R8 start while busy";
    pulse(1, 0);                   // longest shift
    start = 1'b1; re = 16'sd7000; im = 16'sd7000;
    repeat (5) @(negedge clk);
    start = 1'b0;
    while (m_busy != 0 || m_done != 0) @(negedge clk);
    phase = "R5 R6 back-to-back";
    @(negedge clk);
    start = 1'b1; re = 16'sd9; im = -16'sd2;
    repeat (60) @(negedge clk);    // start held: re-accepted right after done
    re = '0; im = '0;
    repeat (6) @(negedge clk);     // zero operands accepted on consecutive cycles
    start = 1'b0;
    repeat (3) @(negedge clk);
    phase = "R10 hold";
    repeat (10) @(negedge clk);
    phase = "R1 R3 random";
    for (int k = 0; k < 400; k++) begin
      int a, b, sh;
      sh = $urandom_range(15, 0);
      a = $signed(16'($urandom)) >>> sh;
      b = $signed(16'($urandom)) >>> $urandom_range(15, 0);
      run(a, b);
    end
    for (int j = 0; j < 32; j++) run(32 + j, 0); // every table entry, e = 5
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule